// File: doc/BRIEF.md
# Key-Locked System Control Register Block

This block is a small bank of system control registers on a plain 32-bit register bus (byte address, write enable, write data, registered read data). Software uses it to keep two sets of general-purpose flag bits, to issue a soft reset of the system, and to read a free-running timestamp that counts at a fixed rate independent of the bus clock frequency.

The soft reset path is guarded by a lock register. Only while that register holds a specific 16-bit key does a write to the reset-control register store a new reset level and produce a one-cycle reset request pulse; at all other times such writes are discarded. Each flag set is modified through a pair of addresses, one where every written 1 sets a bit and one where every written 1 clears a bit, so bits can be changed without a read-modify-write. The volatile flags are wiped by a soft reset request; the non-volatile flags survive it and are cleared only by the hardware reset.

Top module: `keylock_sysctl`

## Requirements
- R1: After hardware reset the flag set (read at 0x30), the non-volatile flag set (read at 0x38) and the reset level (read at 0x40) read as zero, the lock register at 0x20 reads 0x00010000 (locked, stored value zero), and reset_req is low.
- R2: A write of exactly 0x0000A05F to offset 0x20 unlocks the block; the lock register then reads 0x0000A05F (bit 16, the locked indicator, clear).
- R3: A write of any other value to offset 0x20 stores only bits [14:0] of the written data and leaves the block locked; a read returns those 15 bits with bit 16 set.
- R4: Each 1 bit written to offset 0x30 sets the matching volatile flag and each 1 bit written to 0x34 clears it; 0 bits leave flags unchanged, and a read at 0x30 returns the flags.
- R5: Each 1 bit written to 0x38 sets the matching non-volatile flag and each 1 bit written to 0x3C clears it; a read at 0x38 returns them.
- R6: While unlocked, a write to 0x40 stores bits [LEVEL_W-1:0] (8 by default) as the reset level, readable at 0x40, and reset_req is high for exactly the one cycle following the write.
- R7: While locked, a write to 0x40 leaves the reset level unchanged and produces no reset_req pulse.
- R8: A reset_req pulse clears all volatile flags and leaves the non-volatile flags, the lock register and the reset level unchanged.
- R9: Offset 0x5C reads a counter that advances TICK_HZ times per CLK_HZ clock cycles, at most once per cycle; with the defaults (24 MHz in 200 MHz) it advances by exactly 30 every 250 cycles.
- R10: Every other offset, including any with nonzero low two bits and the clear addresses 0x34 and 0x3C, reads as zero, and writes to unmapped offsets change no register.
- R11: Read data is registered: bus_rdata shows the register selected by bus_addr in the previous cycle, with state as it stood before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| reset_req | output | 1 | One-cycle soft reset request pulse |

## Verification
The hardest condition to reach is a reset-control write that arrives while the lock register holds something close to the key but not equal to it, for example the key with an extra upper bit set, which a loose compare would accept. The stimulus first writes near-miss lock values, confirms through lock reads that the block stays locked and that reset-control writes neither pulse reset_req nor alter the level, and only then writes the exact key. The surviving flags are set up before the unlocked reset write so that the one-cycle pulse can be seen clearing the volatile set while the non-volatile set is read back intact.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_LOCK    = 12'h020;
  localparam logic [OFS_W-1:0] OFS_FSET    = 12'h030;
  localparam logic [OFS_W-1:0] OFS_FCLR    = 12'h034;
  localparam logic [OFS_W-1:0] OFS_NVSET   = 12'h038;
  localparam logic [OFS_W-1:0] OFS_NVCLR   = 12'h03C;
  localparam logic [OFS_W-1:0] OFS_RSTCTL  = 12'h040;
  localparam logic [OFS_W-1:0] OFS_TSTAMP  = 12'h05C;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;
  localparam int LOCKED_BIT = 16;
endpackage

// File: rtl/keylock_lock.sv
module keylock_lock
  import keylock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [KEY_W-1:0] val_q,
  output logic             unlocked
);
  localparam logic [31:0] KEY_FULL = {{(32-KEY_W){1'b0}}, UNLOCK_KEY};

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (wr_en) begin
      if (wdata == KEY_FULL) val_q <= UNLOCK_KEY;
      else                   val_q <= {1'b0, wdata[KEY_W-2:0]};
    end
  end

  assign unlocked = (val_q == UNLOCK_KEY);
endmodule

// File: rtl/keylock_flags.sv
module keylock_flags #(
  parameter int W        = 32,
  parameter bit SOFT_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic         soft_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (set_en) nxt = nxt | wdata;
    if (clr_en) nxt = nxt & ~wdata;
  end

  generate
    if (SOFT_CLR) begin : g_volatile
      always_ff @(posedge clk) begin
        if (rst || soft_clr) q <= '0;
        else                 q <= nxt;
      end
    end else begin : g_retained
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/keylock_tstamp.sv
module keylock_tstamp #(
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 24_000_000,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
  localparam logic [ACC_W-1:0] LIM  = ACC_W'(CLK_HZ);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum = acc + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      count <= '0;
    end else if (sum >= LIM) begin
      acc   <= sum - LIM;
      count <= count + 1'b1;
    end else begin
      acc   <= sum;
    end
  end
endmodule

// File: rtl/keylock_sysctl.sv
module keylock_sysctl
  import keylock_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int FLAG_W  = 32,
  parameter int LEVEL_W = 8,
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 24_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              reset_req
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] o);
    return a == ADDR_W'(o);
  endfunction

  logic               unlocked;
  logic [KEY_W-1:0]   lock_val;
  logic [FLAG_W-1:0]  flags_q;
  logic [FLAG_W-1:0]  nvflags_q;
  logic [LEVEL_W-1:0] level_q;
  logic [31:0]        ts_q;
  logic               rst_wr;
  logic [31:0]        rd_nxt;

  keylock_lock u_lock (
    .clk(clk), .rst(rst),
    .wr_en(bus_we && hit(bus_addr, OFS_LOCK)),
    .wdata(bus_wdata),
    .val_q(lock_val), .unlocked(unlocked)
  );

  keylock_flags #(.W(FLAG_W), .SOFT_CLR(1'b1)) u_flags (
    .clk(clk), .rst(rst),
    .set_en(bus_we && hit(bus_addr, OFS_FSET)),
    .clr_en(bus_we && hit(bus_addr, OFS_FCLR)),
    .soft_clr(reset_req),
    .wdata(bus_wdata[FLAG_W-1:0]),
    .q(flags_q)
  );

  keylock_flags #(.W(FLAG_W), .SOFT_CLR(1'b0)) u_nvflags (
    .clk(clk), .rst(rst),
    .set_en(bus_we && hit(bus_addr, OFS_NVSET)),
    .clr_en(bus_we && hit(bus_addr, OFS_NVCLR)),
    .soft_clr(reset_req),
    .wdata(bus_wdata[FLAG_W-1:0]),
    .q(nvflags_q)
  );

  keylock_tstamp #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(32)) u_ts (
    .clk(clk), .rst(rst), .count(ts_q)
  );

  assign rst_wr = bus_we && hit(bus_addr, OFS_RSTCTL) && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q   <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= rst_wr;
      if (rst_wr) level_q <= bus_wdata[LEVEL_W-1:0];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (hit(bus_addr, OFS_LOCK)) begin
      rd_nxt[KEY_W-1:0]  = lock_val;
      rd_nxt[LOCKED_BIT] = !unlocked;
    end else if (hit(bus_addr, OFS_FSET)) begin
      rd_nxt[FLAG_W-1:0] = flags_q;
    end else if (hit(bus_addr, OFS_NVSET)) begin
      rd_nxt[FLAG_W-1:0] = nvflags_q;
    end else if (hit(bus_addr, OFS_RSTCTL)) begin
      rd_nxt[LEVEL_W-1:0] = level_q;
    end else if (hit(bus_addr, OFS_TSTAMP)) begin
      rd_nxt = ts_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/keylock_sysctl_chk.sv
module keylock_sysctl_chk
  import keylock_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int FLAG_W  = 32,
  parameter int LEVEL_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_rdata,
  input logic               reset_req,
  input logic               unlocked,
  input logic [FLAG_W-1:0]  flags_q,
  input logic [FLAG_W-1:0]  nvflags_q,
  input logic [LEVEL_W-1:0] level_q,
  input logic [31:0]        ts_q
);
  logic is_rstctl, mapped, nv_wr;
  assign is_rstctl = (bus_addr == ADDR_W'(OFS_RSTCTL));
  assign nv_wr     = bus_we && (bus_addr == ADDR_W'(OFS_NVSET) || bus_addr == ADDR_W'(OFS_NVCLR));
  assign mapped    = bus_addr == ADDR_W'(OFS_LOCK)   || bus_addr == ADDR_W'(OFS_FSET) ||
                     bus_addr == ADDR_W'(OFS_NVSET)  || is_rstctl ||
                     bus_addr == ADDR_W'(OFS_TSTAMP);

  assert_req_source_R6: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(bus_we && is_rstctl));

  assert_locked_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && is_rstctl && !unlocked) |=> ($stable(level_q) && !reset_req));

  assert_soft_clears_R8: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> (flags_q == '0));

  assert_nv_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (reset_req && !nv_wr) |=> $stable(nvflags_q));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (bus_rdata == 32'd0));

  assert_ts_step_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ts_q - $past(ts_q)) <= 32'd1));
endmodule

bind keylock_sysctl keylock_sysctl_chk #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .reset_req(reset_req), .unlocked(unlocked), .flags_q(flags_q), .nvflags_q(nvflags_q),
  .level_q(level_q), .ts_q(ts_q)
);

// File: tb/keylock_sysctl_test.sv
`timescale 1ns/1ps
module keylock_sysctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  keylock_sysctl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req)
  );

  // Monitor: compares queued expectations with registered read data
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, e);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0, t1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(reset_req, 1'b0, "R1 reset_req low");
    rd(12'h020, 32'h0001_0000, "R1 lock after reset");
    rd(12'h030, 32'h0, "R1 flags after reset");
    rd(12'h038, 32'h0, "R1 nvflags after reset");
    rd(12'h040, 32'h0, "R1 level after reset");

    // R7 locked reset-control write
    wr(12'h040, 32'h0000_005A);
    chk(reset_req, 1'b0, "R7 no pulse while locked");
    @(negedge clk);
    chk(reset_req, 1'b0, "R7 no pulse one cycle later");
    rd(12'h040, 32'h0, "R7 level unchanged");

    // R3 near-miss lock values
    wr(12'h020, 32'h1234_FFFF);
    rd(12'h020, 32'h0001_7FFF, "R3 stores low 15 bits");
    wr(12'h020, 32'h0001_A05F);
    rd(12'h020, 32'h0001_205F, "R3 key with upper bit stays locked");
    wr(12'h040, 32'h0000_0033);
    chk(reset_req, 1'b0, "R7 no pulse after near-miss");
    rd(12'h040, 32'h0, "R7 level unchanged after near-miss");

    // R2 exact key
    wr(12'h020, 32'h0000_A05F);
    rd(12'h020, 32'h0000_A05F, "R2 unlocked read");

    // R4 volatile flags
    wr(12'h030, 32'hF0F0_000F);
    wr(12'h030, 32'h0000_0100);
    rd(12'h030, 32'hF0F0_010F, "R4 set accumulates");
    wr(12'h034, 32'hF000_0001);
    rd(12'h030, 32'h00F0_010E, "R4 clear");
    rd(12'h034, 32'h0, "R10 clear address reads zero");

    // R5 non-volatile flags
    wr(12'h038, 32'hDEAD_0000);
    wr(12'h03C, 32'h00AD_0000);
    rd(12'h038, 32'hDE00_0000, "R5 nv set and clear");
    rd(12'h03C, 32'h0, "R10 nv clear address reads zero");

    // R10 unmapped writes and reads
    wr(12'h044, 32'hFFFF_FFFF);
    wr(12'h031, 32'hFFFF_FFFF);
    wr(12'h03A, 32'hFFFF_FFFF);
    rd(12'h044, 32'h0, "R10 unmapped 0x44");
    rd(12'h031, 32'h0, "R10 misaligned 0x31");
    rd(12'h030, 32'h00F0_010E, "R10 flags untouched");
    rd(12'h038, 32'hDE00_0000, "R10 nvflags untouched");
    rd(12'h020, 32'h0000_A05F, "R10 lock untouched");

    // R11 read registered before same-cycle write takes effect
    @(negedge clk);
    bus_addr = 12'h030; bus_we = 1'b1; bus_wdata = 32'h0000_1000;
    @(posedge clk);
    begin item_t it; it.exp = 32'h00F0_010E; it.tag = "R11 old value on write cycle"; sb.push_back(it); end
    @(negedge clk);
    bus_we = 1'b0;
    rd(12'h030, 32'h00F0_110E, "R11 new value next read");

    // R6 / R8 unlocked reset request
    wr(12'h040, 32'h0000_01A5);
    chk(reset_req, 1'b1, "R6 pulse after unlocked write");
    @(negedge clk);
    chk(reset_req, 1'b0, "R6 pulse is one cycle");
    rd(12'h040, 32'h0000_00A5, "R6 level stored");
    rd(12'h030, 32'h0, "R8 volatile flags cleared");
    rd(12'h038, 32'hDE00_0000, "R8 nv flags kept");
    rd(12'h020, 32'h0000_A05F, "R8 lock kept");

    // R9 timestamp rate
    @(negedge clk);
    bus_addr = 12'h05C;
    @(negedge clk);
    @(negedge clk);
    t0 = bus_rdata;
    repeat (250) @(negedge clk);
    t1 = bus_rdata;
    checks++;
    if (t1 - t0 !== 32'd30) begin
      errors++;
      $display("FAIL R9 timestamp delta: actual=%0d expected=30", t1 - t0);
    end
    checks++;
    if (t0 == 32'd0) begin
      errors++;
      $display("FAIL R9 timestamp running: actual=%0d expected=nonzero", t0);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule